// File: doc/BRIEF.md
# PCI-to-ISA Interrupt Steering Unit

This unit sits in front of a pair of cascaded 8259-style interrupt controllers. It takes four active-low, level-sensitive PCI interrupt lines, inverts them, and steers each one onto one of sixteen ISA request lines chosen by a per-input route register. The legacy ISA request inputs are merged with the steered PCI requests, so that any mix of sources reaching the same line is combined with a logical OR.

A per-line trigger control then shapes each merged request before it leaves the block. In level mode the output follows the merged request. In edge mode a rising edge of the merged request produces a one-cycle pulse. Four lines are reserved for system use and can never receive a PCI input: IRQ0 (timer), IRQ2 (cascade), IRQ8 (clock) and IRQ13. Five lines keep a fixed edge trigger whatever software writes: IRQ0, IRQ1, IRQ2, IRQ8 and IRQ13.

Software uses a small synchronous register port. Each PCI input has one route register and each half of the trigger map has one control register. Reads are combinational from the address.

Top module: `irq_steer_top`

## Requirements
- R1: After synchronous reset, the four route registers (addresses 0..3) read 0x80, the trigger registers (addresses 4 and 5) read 0x00, and `irq_out` is all zero.
- R2: Route register layout is as follows. Address 0..3 serves PCI input 0..3. Bit 7 is the disable bit and bits 3:0 hold the ISA line number. Bits 6:4 read as zero, so a written value reads back ANDed with 0x8F.
- R3: An enabled route (bit 7 clear) to a non-reserved line N drives `irq_out[N]` while its `pci_int_n` bit is low. The PCI pin is active low.
- R4: A route whose disable bit is set has no effect on any `irq_out` bit.
- R5: A route whose line number is 0, 2, 8 or 13 has no effect on any `irq_out` bit.
- R6: All requests aimed at one line are combined with a logical OR. These are the legacy `isa_irq_in` bit and every PCI input routed to that line.
- R7: Address 4 bit b sets the trigger of line b, and address 5 bit b sets the trigger of line b+8. A value of 1 means level and 0 means edge. Writable bits read back as written.
- R8: Trigger bits for lines 0, 1, 2, 8 and 13 always read 0 and ignore writes, and those lines always behave in edge mode.
- R9: For a line in level mode, `irq_out[i]` equals the merged request of the previous clock cycle.
- R10: For a line in edge mode, `irq_out[i]` is 1 for exactly one cycle, the cycle after the merged request goes from 0 to 1. A held request gives no further pulse.
- R11: Addresses 6 and 7 read 0x00, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pci_int_n | input | 4 | Active-low PCI interrupt inputs |
| isa_irq_in | input | 16 | Legacy ISA request inputs, active high |
| irq_out | output | 16 | Shaped requests to the cascaded controllers |

## Verification
A corrupted route register shows at the ports in two ways. It appears on the next read of that address. It also appears one cycle after its PCI pin falls, as a missing request on the intended line or a stray request on another line. A wrong edge-history bit shows as a doubled or missing pulse in the cycle after the merged request changes. A wrong trigger bit shows as an edge-mode line staying high, or a level-mode line dropping after one cycle. The bench reference model predicts `irq_out` and the read data for every cycle, so any such divergence appears within one clock of the stimulus that exposes it.

// File: rtl/irq_steer_pkg.sv
// Package: shared constants and types for the interrupt steering unit.
// Assumes sixteen ISA request lines and eight-bit software registers.
package irq_steer_pkg;
    localparam int IRQ_COUNT = 16;
    localparam int SEL_W     = $clog2(IRQ_COUNT);
    localparam int REG_W     = 8;
    localparam int HALF_W    = IRQ_COUNT / 2;

    // Lines that a PCI input may never drive: 0, 2, 8, 13.
    localparam logic [IRQ_COUNT-1:0] RESERVED_MASK = 16'h2105;
    // Lines whose trigger is fixed to edge: 0, 1, 2, 8, 13.
    localparam logic [IRQ_COUNT-1:0] FIXED_MASK    = 16'h2107;

    typedef struct packed {
        logic             dis;
        logic [SEL_W-1:0] sel;
    } route_t;

    localparam route_t ROUTE_RST = '{dis: 1'b1, sel: '0};
endpackage

// File: rtl/irq_route_regs.sv
// Module: software register file holding the route and trigger settings.
// Assumes route registers at addresses 0..NUM_PCI-1, followed by the low and
// high trigger registers. Reads are combinational and writes take effect on clk.
module irq_route_regs
    import irq_steer_pkg::*;
#(
    parameter int NUM_PCI = 4,
    parameter int ADDR_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [REG_W-1:0]           wdata,
    output logic [REG_W-1:0]           rdata,
    output route_t [NUM_PCI-1:0]       routes,
    output logic [IRQ_COUNT-1:0]       level_mask
);
    localparam int TRIG_LO = NUM_PCI;
    localparam int TRIG_HI = NUM_PCI + 1;
    localparam int PAD_W   = REG_W - 1 - SEL_W;

    logic [IRQ_COUNT-1:0] level_q;

    for (genvar p = 0; p < NUM_PCI; p++) begin : g_route
        // Holds one route register, cleared to the disabled state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                routes[p] <= ROUTE_RST;
            end else if (we && addr == ADDR_W'(p)) begin
                routes[p] <= '{dis: wdata[REG_W-1], sel: wdata[SEL_W-1:0]};
            end
        end
    end

    // Holds the trigger map, with fixed-line bits forced to edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (we && addr == ADDR_W'(TRIG_LO)) begin
            level_q[HALF_W-1:0] <= wdata & ~FIXED_MASK[HALF_W-1:0];
        end else if (we && addr == ADDR_W'(TRIG_HI)) begin
            level_q[IRQ_COUNT-1:HALF_W] <= wdata & ~FIXED_MASK[IRQ_COUNT-1:HALF_W];
        end
    end

    assign level_mask = level_q;

    // Selects the read data for the addressed register.
    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PCI; p++) begin
            if (addr == ADDR_W'(p)) begin
                rdata = {routes[p].dis, {PAD_W{1'b0}}, routes[p].sel};
            end
        end
        if (addr == ADDR_W'(TRIG_LO)) begin
            rdata = level_q[HALF_W-1:0];
        end
        if (addr == ADDR_W'(TRIG_HI)) begin
            rdata = level_q[IRQ_COUNT-1:HALF_W];
        end
    end
endmodule

// File: rtl/irq_route_matrix.sv
// Module: inverts the PCI lines and ORs each routed one, together with the
// legacy request, onto its ISA line. Purely combinational. Assumes that a
// route is valid only when enabled and aimed at a non-reserved line.
module irq_route_matrix
    import irq_steer_pkg::*;
#(
    parameter int NUM_PCI = 4
) (
    input  logic [NUM_PCI-1:0]    pci_int_n,
    input  logic [IRQ_COUNT-1:0]  isa_irq_in,
    input  route_t [NUM_PCI-1:0]  routes,
    output logic [IRQ_COUNT-1:0]  comb_req
);
    logic [NUM_PCI-1:0] pci_live;

    for (genvar p = 0; p < NUM_PCI; p++) begin : g_src
        // Marks a PCI input as asserted and allowed onto its selected line.
        always_comb begin
            pci_live[p] = !pci_int_n[p] && !routes[p].dis
                          && !RESERVED_MASK[routes[p].sel];
        end
    end

    for (genvar i = 0; i < IRQ_COUNT; i++) begin : g_line
        // Merges the legacy request with every PCI input aimed at this line.
        always_comb begin
            comb_req[i] = isa_irq_in[i];
            for (int p = 0; p < NUM_PCI; p++) begin
                if (pci_live[p] && routes[p].sel == SEL_W'(i)) begin
                    comb_req[i] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irq_trigger_stage.sv
// Module: shapes each merged request per line, either following it (level)
// or emitting a one-cycle pulse on its rising edge (edge). The output is
// registered. Assumes fixed lines are edge regardless of the mask.
module irq_trigger_stage
    import irq_steer_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IRQ_COUNT-1:0]  comb_req,
    input  logic [IRQ_COUNT-1:0]  level_mask,
    output logic [IRQ_COUNT-1:0]  irq_out
);
    logic [IRQ_COUNT-1:0] prev_req;

    for (genvar i = 0; i < IRQ_COUNT; i++) begin : g_trig
        if (FIXED_MASK[i]) begin : g_fixed
            // Fixed line: always an edge pulse on a rising request.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_req[i] <= 1'b0;
                    irq_out[i]  <= 1'b0;
                end else begin
                    prev_req[i] <= comb_req[i];
                    irq_out[i]  <= comb_req[i] & ~prev_req[i];
                end
            end
        end else begin : g_prog
            // Programmable line: level follows, edge pulses once.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_req[i] <= 1'b0;
                    irq_out[i]  <= 1'b0;
                end else begin
                    prev_req[i] <= comb_req[i];
                    irq_out[i]  <= level_mask[i] ? comb_req[i]
                                                 : (comb_req[i] & ~prev_req[i]);
                end
            end
        end
    end
endmodule

// File: rtl/irq_steer_top.sv
// Module: top of the PCI-to-ISA interrupt steering unit. Connects the
// register file, the routing matrix and the trigger shaping stage.
// Assumes a single clock and a synchronous active-low reset.
module irq_steer_top
    import irq_steer_pkg::*;
#(
    parameter int NUM_PCI = 4,
    parameter int ADDR_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic [NUM_PCI-1:0]    pci_int_n,
    input  logic [IRQ_COUNT-1:0]  isa_irq_in,
    output logic [IRQ_COUNT-1:0]  irq_out
);
    route_t [NUM_PCI-1:0]  routes;
    logic [IRQ_COUNT-1:0]  level_mask;
    logic [IRQ_COUNT-1:0]  comb_req;

    irq_route_regs #(.NUM_PCI(NUM_PCI), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .routes     (routes),
        .level_mask (level_mask)
    );

    irq_route_matrix #(.NUM_PCI(NUM_PCI)) u_matrix (
        .pci_int_n  (pci_int_n),
        .isa_irq_in (isa_irq_in),
        .routes     (routes),
        .comb_req   (comb_req)
    );

    irq_trigger_stage u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .comb_req   (comb_req),
        .level_mask (level_mask),
        .irq_out    (irq_out)
    );
endmodule

// File: rtl/irq_steer_checker.sv
// Module: property checker for the steering unit, bound to the top module.
// Assumes the default register map (trigger registers right after the routes).
module irq_steer_checker
    import irq_steer_pkg::*;
#(
    parameter int NUM_PCI = 4,
    parameter int ADDR_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_rdata,
    input  logic [IRQ_COUNT-1:0]  isa_irq_in,
    input  logic [IRQ_COUNT-1:0]  irq_out,
    input  logic [IRQ_COUNT-1:0]  comb_req,
    input  logic [IRQ_COUNT-1:0]  level_mask
);
    localparam int TRIG_LO = NUM_PCI;
    localparam int TRIG_HI = NUM_PCI + 1;

    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & RESERVED_MASK & ~$past(isa_irq_in)) == '0); // R5

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~$past(comb_req)) == '0); // R6

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out ^ $past(comb_req)) & $past(level_mask)) == '0); // R9

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & $past(irq_out) & ~$past(level_mask)) == '0); // R10

    AST_FIXED_LO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == ADDR_W'(TRIG_LO) |-> (reg_rdata & FIXED_MASK[HALF_W-1:0]) == '0); // R8

    AST_FIXED_HI_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == ADDR_W'(TRIG_HI) |-> (reg_rdata & FIXED_MASK[IRQ_COUNT-1:HALF_W]) == '0); // R8

    AST_UNUSED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr > ADDR_W'(TRIG_HI) |-> reg_rdata == '0); // R11
endmodule

bind irq_steer_top irq_steer_checker #(.NUM_PCI(NUM_PCI), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .isa_irq_in (isa_irq_in),
    .irq_out    (irq_out),
    .comb_req   (comb_req),
    .level_mask (level_mask)
);

// File: tb/tb_irq_steer_top.sv
`timescale 1ns/1ps
module tb_irq_steer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [3:0]  pci_int_n = 4'hF;
    logic [15:0] isa_irq_in = '0;
    logic [15:0] irq_out;

    always #2.5 clk = ~clk;

    irq_steer_top dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pci_int_n(pci_int_n),
        .isa_irq_in(isa_irq_in), .irq_out(irq_out)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // Behavioural reference state
    int m_route [4];
    int m_lvl   [16];
    int m_prev  [16];
    int m_out   [16];

    function automatic bit is_res(int n);
        return n == 0 || n == 2 || n == 8 || n == 13;
    endfunction

    function automatic bit is_fix(int n);
        return is_res(n) || n == 1;
    endfunction

    function automatic int model_read(int a);
        int v = 0;
        if (a < 4) return m_route[a];
        if (a == 4) begin
            for (int b = 0; b < 8; b++) v += m_lvl[b] << b;
            return v;
        end
        if (a == 5) begin
            for (int b = 0; b < 8; b++) v += m_lvl[b+8] << b;
            return v;
        end
        return 0;
    endfunction

    function automatic int exp_vec();
        int v = 0;
        for (int i = 0; i < 16; i++) v += m_out[i] << i;
        return v;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // One clock: predict from the current inputs, advance, compare at negedge.
    task automatic cycle();
        int nout [16];
        int nprev[16];
        for (int i = 0; i < 16; i++) begin
            int c = isa_irq_in[i];
            for (int p = 0; p < 4; p++) begin
                int s = m_route[p] & 15;
                if (!pci_int_n[p] && (m_route[p] & 128) == 0 && !is_res(s) && s == i)
                    c = 1;
            end
            nprev[i] = rst_n ? c : 0;
            nout[i]  = !rst_n ? 0 : (m_lvl[i] != 0 ? c : (c != 0 && m_prev[i] == 0));
        end
        @(posedge clk);
        for (int i = 0; i < 16; i++) begin
            m_out[i]  = nout[i];
            m_prev[i] = nprev[i];
        end
        if (!rst_n) begin
            for (int p = 0; p < 4; p++) m_route[p] = 8'h80;
            for (int i = 0; i < 16; i++) m_lvl[i] = 0;
        end else if (reg_we) begin
            if (reg_addr < 4) m_route[reg_addr] = reg_wdata & 8'h8F;
            else if (reg_addr == 4)
                for (int b = 0; b < 8; b++) m_lvl[b] = is_fix(b) ? 0 : reg_wdata[b];
            else if (reg_addr == 5)
                for (int b = 0; b < 8; b++) m_lvl[b+8] = is_fix(b+8) ? 0 : reg_wdata[b];
        end
        @(negedge clk);
        check(irq_out == 16'(exp_vec()), cur_req, "irq_out model", irq_out, exp_vec());
        check(reg_rdata == 8'(model_read(reg_addr)), cur_req, "rdata model",
              reg_rdata, model_read(reg_addr));
    endtask

    task automatic wr(int a, int d);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        cycle();
        reg_we = 1'b0;
    endtask

    task automatic rd(int a, int expv, string req);
        reg_addr = 3'(a);
        #1;
        check(reg_rdata == 8'(expv), req, $sformatf("read addr %0d", a), reg_rdata, expv);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 4; p++) m_route[p] = 8'h80;
        for (int i = 0; i < 16; i++) begin m_lvl[i] = 0; m_prev[i] = 0; m_out[i] = 0; end
        @(negedge clk);
        repeat (3) cycle();
        rst_n = 1'b1;
        cycle();

        // R1 reset state
        for (int a = 0; a < 4; a++) rd(a, 8'h80, "R1");
        rd(4, 0, "R1");
        rd(5, 0, "R1");
        check(irq_out == 0, "R1", "irq_out after reset", irq_out, 0);

        // R2 route readback
        cur_req = "R2";
        wr(0, 8'h05); rd(0, 8'h05, "R2");
        wr(1, 8'hFF); rd(1, 8'h8F, "R2");
        wr(2, 8'h3C); rd(2, 8'h0C, "R2");

        // R3 active-low PCI routed to line 5 (level)
        cur_req = "R3";
        wr(4, 8'h20);
        wr(0, 8'h05);
        pci_int_n = 4'hE; cycle();
        check(irq_out[5] == 1'b1, "R3", "line 5 asserted", irq_out[5], 1);
        pci_int_n = 4'hF; cycle();
        check(irq_out[5] == 1'b0, "R3", "line 5 released", irq_out[5], 0);

        // R4 disabled route to line 10 (level)
        cur_req = "R4";
        wr(1, 8'h8A); wr(5, 8'h04);
        pci_int_n = 4'hD; repeat (3) cycle();
        check(irq_out == 0, "R4", "disabled route quiet", irq_out, 0);
        pci_int_n = 4'hF; cycle();

        // R5 reserved destinations
        cur_req = "R5";
        foreach (m_lvl[k]) begin
            if (is_res(k)) begin
                wr(2, k);
                pci_int_n = 4'hB; cycle(); cycle();
                check(irq_out == 0, "R5", $sformatf("reserved line %0d", k), irq_out, 0);
                pci_int_n = 4'hF; cycle();
            end
        end

        // R6 OR of several sources on line 5
        cur_req = "R6";
        wr(3, 8'h05);
        pci_int_n = 4'h7; cycle();
        check(irq_out[5] == 1'b1, "R6", "D alone", irq_out[5], 1);
        pci_int_n = 4'hF; isa_irq_in = 16'h0020; cycle();
        check(irq_out[5] == 1'b1, "R6", "legacy alone", irq_out[5], 1);
        isa_irq_in = 0; pci_int_n = 4'h6; cycle();
        check(irq_out[5] == 1'b1, "R6", "A and D", irq_out[5], 1);
        pci_int_n = 4'hF; cycle();
        check(irq_out[5] == 1'b0, "R6", "all released", irq_out[5], 0);

        // R7 trigger register readback
        cur_req = "R7";
        wr(4, 8'hF8); rd(4, 8'hF8, "R7");
        wr(5, 8'h12); rd(5, 8'h12, "R7");

        // R8 fixed trigger bits
        cur_req = "R8";
        wr(5, 8'hFF); rd(5, 8'hDE, "R8");
        wr(4, 8'hFF); rd(4, 8'hF8, "R8");
        isa_irq_in = 16'h0002; cycle();
        check(irq_out[1] == 1'b1, "R8", "line 1 pulse", irq_out[1], 1);
        cycle();
        check(irq_out[1] == 1'b0, "R8", "line 1 edge only", irq_out[1], 0);
        isa_irq_in = 0; cycle();

        // R9 level follow on line 5
        cur_req = "R9";
        isa_irq_in = 16'h0020;
        for (int n = 0; n < 3; n++) begin
            cycle();
            check(irq_out[5] == 1'b1, "R9", "level held", irq_out[5], 1);
        end
        isa_irq_in = 0; cycle();
        check(irq_out[5] == 1'b0, "R9", "level dropped", irq_out[5], 0);

        // R10 edge pulses
        cur_req = "R10";
        wr(4, 8'h00);
        isa_irq_in = 16'h0020; cycle();
        check(irq_out[5] == 1'b1, "R10", "edge pulse", irq_out[5], 1);
        cycle();
        check(irq_out[5] == 1'b0, "R10", "pulse one cycle", irq_out[5], 0);
        cycle();
        check(irq_out[5] == 1'b0, "R10", "held no repulse", irq_out[5], 0);
        isa_irq_in = 0; cycle();
        wr(5, 8'h00); wr(0, 8'h0A);
        pci_int_n = 4'hE; cycle();
        check(irq_out[10] == 1'b1, "R10", "routed edge pulse", irq_out[10], 1);
        cycle();
        check(irq_out[10] == 1'b0, "R10", "routed pulse ends", irq_out[10], 0);
        pci_int_n = 4'hF; cycle();

        // R11 unused addresses
        cur_req = "R11";
        wr(6, 8'hAA); rd(6, 0, "R11");
        wr(7, 8'h55); rd(7, 0, "R11");
        rd(0, 8'h0A, "R11");
        rd(3, 8'h05, "R11");
        rd(5, 8'h00, "R11");
        check(irq_out == 0, "R11", "no output change", irq_out, 0);

        // Random traffic against the reference model
        cur_req = "R9";
        for (int n = 0; n < 3000; n++) begin
            reg_we     = ($urandom % 6) == 0;
            reg_addr   = 3'($urandom);
            reg_wdata  = 8'($urandom);
            pci_int_n  = 4'($urandom);
            isa_irq_in = 16'($urandom & $urandom & $urandom);
            cycle();
        end
        reg_we = 1'b0;

        done = 1;
        summary();
        $finish;
    end
endmodule